// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is an 8-bit down counter driven through a 7-bit down-counting prescaler. The prescaler advances on count events. A count event comes either from a fixed divide-by-12 of the system clock or from rising edges on an external timer pin, which is first synchronised to the system clock. A 3-bit tap select decides how often the counter steps: every count event, or each time one chosen prescaler bit rises. That gives division factors of 1, 2, 4 and so on up to 128, and up to 2^15 events per full counter cycle.

Software uses a small 8-bit register bus with a combinational read path. Address 0 is status/control, address 1 is the counter and address 2 is the prescaler. Whenever the counter steps from 1 to 0 it raises a sticky zero flag. An interrupt level is driven while that flag and the enable bit are both set. A prescaler-initialise bit stops everything: while it is clear the prescaler is held at all ones and the counter is frozen.

Top module: `prescaled_down_timer`

## Requirements
- R1: After reset, address 0 (status/control) reads 0x00, address 1 (counter) reads 0xFF, address 2 (prescaler) reads 0x7F, and irqOut is 0.
- R2: While status/control bit 3 (initialise) is 0, the prescaler reads 0x7F and the counter does not change on count events.
- R3: A write to the prescaler takes effect only while bit 3 is 1. The written 7-bit value reads back at address 2.
- R4: While bit 3 is 1, the prescaler decrements by one on each count event and wraps from 0x00 to 0x7F.
- R5: With select field bits 2..0 = n, the counter decrements once per 2^n count events. For n>0 the step happens on the event that takes prescaler bits n-1..0 from all zeros to all ones.
- R6: A counter decrement from 1 to 0 sets bit 7 (zero flag) of status/control.
- R7: irqOut is 1 exactly while bit 7 and bit 6 (interrupt enable) are both 1.
- R8: From 0 the counter wraps to 0xFF on its next step and keeps counting. Bit 7 stays set until software writes 0 to it, and writing 1 to it never sets it.
- R9: With bit 4 = 0, count events occur once every 12 clocks. With bit 4 = 1, each rising edge of extPin makes one count event, on the third clock edge after the pin rises.
- R10: A counter write in the same cycle as a counter decrement wins: the written value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register address: 0 status/control, 1 counter, 2 prescaler |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data of the addressed register |
| extPin | input | 1 | External count input, asynchronous |
| irqOut | output | 1 | Interrupt request level |

## Verification
A register write is visible on the read port in the cycle after the clock edge that samples it. The bench drives every bus access just after a rising edge and samples at the following falling edge. An external pin edge steps the prescaler three clock edges after the pin rises, so each pulse the bench makes holds the pin high for three cycles and low for three cycles before any read is queued. The write-versus-decrement case is placed exactly on that third edge. The internal source is checked over a window of 120 edges, which holds exactly ten divide-by-12 events whatever the divider phase is, so the expected counter value is known without knowing the phase.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned PSC_W = 7;
  localparam int unsigned SEL_W = $clog2(PSC_W + 1);
  localparam int unsigned BUS_W = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_PSC  = 2'd2;

  typedef struct packed {
    logic             srcTick;
    logic             pscWr;
    logic             cntWr;
    logic             initOn;
    logic [SEL_W-1:0] tapSel;
    logic [BUS_W-1:0] wrData;
  } pdt_strobe_t;
endpackage

// File: rtl/pdt_ctrl.sv
module pdt_ctrl
  import pdt_pkg::*;
#(
  parameter int unsigned DIV_RATIO = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [BUS_W-1:0] regWrData,
  input  logic             extPin,
  input  logic             zeroHit,
  input  logic [CNT_W-1:0] cntVal,
  input  logic [PSC_W-1:0] pscVal,
  output pdt_strobe_t      strobe,
  output logic [BUS_W-1:0] regRdData,
  output logic             irqOut
);
  localparam int unsigned DIV_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_RATIO - 1);

  logic             zeroFlag;
  logic             irqEn;
  logic             modeHi;
  logic             extSel;
  logic             initBit;
  logic [SEL_W-1:0] tapSel;

  logic             syncA, syncB, syncPrev;
  logic             extTick;
  logic [DIV_W-1:0] divCnt;
  logic             divTick;
  logic             ctrlWr;

  assign ctrlWr = regWrEn && (regAddr == ADDR_CTRL);

  // external pin: two-flop synchroniser, then rising-edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= extPin;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end
  assign extTick = syncB && !syncPrev;

  // internal fixed divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end
  assign divTick = (divCnt == DIV_LAST);

  // status/control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn   <= 1'b0;
      modeHi  <= 1'b0;
      extSel  <= 1'b0;
      initBit <= 1'b0;
      tapSel  <= '0;
    end else if (ctrlWr) begin
      irqEn   <= regWrData[6];
      modeHi  <= regWrData[5];
      extSel  <= regWrData[4];
      initBit <= regWrData[3];
      tapSel  <= regWrData[SEL_W-1:0];
    end
  end

  // zero flag: set by hardware, cleared only by a written 0; set wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) zeroFlag <= 1'b0;
    else if (zeroHit) zeroFlag <= 1'b1;
    else if (ctrlWr && !regWrData[7]) zeroFlag <= 1'b0;
  end

  always_comb begin
    strobe.srcTick = extSel ? extTick : divTick;
    strobe.pscWr   = regWrEn && (regAddr == ADDR_PSC);
    strobe.cntWr   = regWrEn && (regAddr == ADDR_CNT);
    strobe.initOn  = initBit;
    strobe.tapSel  = tapSel;
    strobe.wrData  = regWrData;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL: regRdData = {zeroFlag, irqEn, modeHi, extSel, initBit, tapSel};
      ADDR_CNT:  regRdData = cntVal;
      ADDR_PSC:  regRdData = {{(BUS_W-PSC_W){1'b0}}, pscVal};
      default:   regRdData = '0;
    endcase
  end

  assign irqOut = zeroFlag && irqEn;

  a_r6_zero_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    zeroHit |=> zeroFlag);
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (zeroFlag && !(ctrlWr && !regWrData[7])) |=> zeroFlag);
  a_r9_ext_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    extTick |=> !extTick);
endmodule

// File: rtl/pdt_datapath.sv
module pdt_datapath
  import pdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  pdt_strobe_t      strobe,
  output logic [CNT_W-1:0] cntVal,
  output logic [PSC_W-1:0] pscVal,
  output logic             zeroHit
);
  localparam logic [PSC_W-1:0] PSC_ONES = '1;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [PSC_W:0] tapVec;
  logic           tapEdge;
  logic           cntStep;

  // tap 0 is the prescaler input itself; tap k+1 fires when bits k..0 borrow
  assign tapVec[0] = strobe.srcTick;
  for (genvar k = 0; k < PSC_W; k++) begin : g_tap
    assign tapVec[k+1] = strobe.srcTick && (pscVal[k:0] == '0);
  end
  assign tapEdge = tapVec[strobe.tapSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pscVal <= PSC_ONES;
    else if (!strobe.initOn) pscVal <= PSC_ONES;
    else if (strobe.pscWr) pscVal <= strobe.wrData[PSC_W-1:0];
    else if (strobe.srcTick) pscVal <= pscVal - 1'b1;
  end

  assign cntStep = tapEdge && strobe.initOn && !strobe.cntWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntVal <= '1;
    else if (strobe.cntWr) cntVal <= strobe.wrData[CNT_W-1:0];
    else if (cntStep) cntVal <= cntVal - 1'b1;
  end

  assign zeroHit = cntStep && (cntVal == CNT_ONE);

  a_r2_psc_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.initOn |=> (pscVal == PSC_ONES));
  a_r4_psc_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.initOn && strobe.srcTick && !strobe.pscWr)
      |=> (pscVal == PSC_W'($past(pscVal) - 1'b1)));
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (cntStep && cntVal == '0) |=> (cntVal == '1));
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntWr |=> (cntVal == $past(strobe.wrData[CNT_W-1:0])));
  a_r2_cnt_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.initOn && !strobe.cntWr) |=> $stable(cntVal));
endmodule

// File: rtl/prescaled_down_timer.sv
module prescaled_down_timer
  import pdt_pkg::*;
#(
  parameter int unsigned DIV_RATIO = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       extPin,
  output logic       irqOut
);
  pdt_strobe_t      strobe;
  logic [CNT_W-1:0] cntVal;
  logic [PSC_W-1:0] pscVal;
  logic             zeroHit;

  pdt_ctrl #(.DIV_RATIO(DIV_RATIO)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .extPin    (extPin),
    .zeroHit   (zeroHit),
    .cntVal    (cntVal),
    .pscVal    (pscVal),
    .strobe    (strobe),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );

  pdt_datapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cntVal  (cntVal),
    .pscVal  (pscVal),
    .zeroHit (zeroHit)
  );
endmodule

// File: tb/prescaled_down_timer_tb.sv
module prescaled_down_timer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       extPin = 1'b0;
  logic       irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  typedef struct {
    bit         isIrq;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t expQ[$];
  logic  probe = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  prescaled_down_timer dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .extPin(extPin), .irqOut(irqOut)
  );

  // monitor: pops one expected item per probe and compares mid-cycle
  always @(negedge clk) begin
    if (probe && expQ.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = expQ.pop_front();
      act = it.isIrq ? {7'd0, irqOut} : regRdData;
      testsRun++;
      if (act !== it.exp) begin
        testsFailed++;
        $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expectReg(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk); #2;
    regAddr = a;
    it.isIrq = 1'b0; it.exp = e; it.tag = tag;
    expQ.push_back(it);
    probe = 1'b1;
    @(negedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic expectIrq(input logic e, input string tag);
    item_t it;
    @(posedge clk); #2;
    it.isIrq = 1'b1; it.exp = {7'd0, e}; it.tag = tag;
    expQ.push_back(it);
    probe = 1'b1;
    @(negedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #2;
    regWrEn = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2; extPin = 1'b1;
      repeat (3) @(posedge clk);
      #2; extPin = 1'b0;
      repeat (3) @(posedge clk);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    // R1 reset state
    expectReg(2'd0, 8'h00, "R1 ctrl reset");
    expectReg(2'd1, 8'hFF, "R1 counter reset");
    expectReg(2'd2, 8'h7F, "R1 prescaler reset");
    expectIrq(1'b0, "R1 irq reset");

    // R2/R3: initialise bit clear freezes everything
    busWrite(2'd0, 8'h10);
    busWrite(2'd1, 8'h05);
    pulses(3);
    expectReg(2'd1, 8'h05, "R2 counter frozen");
    expectReg(2'd2, 8'h7F, "R2 prescaler held");
    busWrite(2'd2, 8'h10);
    expectReg(2'd2, 8'h7F, "R3 prescaler write ignored");

    // R4/R5 factor 1 with external source (R9)
    busWrite(2'd0, 8'h18);
    pulses(3);
    expectReg(2'd1, 8'h02, "R5 factor1 counter");
    expectReg(2'd2, 8'h7C, "R4 prescaler steps R9 ext");
    busWrite(2'd2, 8'h55);
    expectReg(2'd2, 8'h55, "R3 prescaler readback");

    // R5 factor 4, R4 wrap 00->7F
    busWrite(2'd0, 8'h1A);
    busWrite(2'd2, 8'h03);
    busWrite(2'd1, 8'd20);
    pulses(3);
    expectReg(2'd1, 8'd20, "R5 factor4 no step yet");
    expectReg(2'd2, 8'h00, "R4 prescaler at zero");
    pulses(1);
    expectReg(2'd1, 8'd19, "R5 factor4 first step");
    expectReg(2'd2, 8'h7F, "R4 prescaler wrap");
    pulses(4);
    expectReg(2'd1, 8'd18, "R5 factor4 second step");

    // R6/R7/R8 zero flag, interrupt level, wrap
    busWrite(2'd0, 8'h18);
    busWrite(2'd1, 8'h02);
    pulses(1);
    expectReg(2'd0, 8'h18, "R6 flag clear before zero");
    pulses(1);
    expectReg(2'd0, 8'h98, "R6 flag set at zero");
    expectIrq(1'b0, "R7 irq masked");
    busWrite(2'd0, 8'hD8);
    expectIrq(1'b1, "R7 irq asserted");
    pulses(1);
    expectReg(2'd1, 8'hFF, "R8 counter wraps");
    expectReg(2'd0, 8'hD8, "R8 flag sticky");
    busWrite(2'd0, 8'h58);
    expectReg(2'd0, 8'h58, "R8 flag cleared by 0");
    expectIrq(1'b0, "R7 irq drops");
    busWrite(2'd0, 8'hD8);
    expectReg(2'd0, 8'h58, "R8 writing 1 does not set");
    busWrite(2'd0, 8'h18);

    // R10: write on the same edge as a decrement
    @(posedge clk); #2; extPin = 1'b1;
    @(posedge clk);
    @(posedge clk); #2;
    regAddr = 2'd1; regWrData = 8'h42; regWrEn = 1'b1;
    @(posedge clk); #2;
    regWrEn = 1'b0; extPin = 1'b0;
    repeat (3) @(posedge clk);
    expectReg(2'd1, 8'h42, "R10 write beats decrement");

    // R9 internal divide-by-12 source
    busWrite(2'd0, 8'h08);
    busWrite(2'd1, 8'd50);
    repeat (119) @(posedge clk);
    expectReg(2'd1, 8'd40, "R9 internal ten steps in 120 clocks");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog (R1..): actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule